// File: doc/BRIEF.md
# Receive Status Ring Writer

This block is the completion side of a descriptor-driven receive path. When the MAC reports a finished frame, the block looks at the next free receive descriptor in a descriptor ring. It packs a two-word status entry from the frame's length and error flags and from that descriptor's buffer index. It then writes the entry into a status ring held in local memory and advances the pointers of both rings. Software walks the status ring in order and reads each entry through a one-cycle read port. Software zeroes an entry once it has taken it, and hands slots back by pulsing a count into either of two enqueue inputs, one per ring.

Each ring has its own credit counter of free slots. A frame is accepted only when both counters are non-zero. If either counter is zero, the frame is dropped: no entry is written and a saturating drop counter counts the loss. Both rings are windows of a shared-depth memory, set by a base index and a length in entries. After each entry is written, a sticky receive interrupt is raised if it is enabled.

Top module: `rx_stat_ring_wr`

## Requirements
- R1: After reset both credit counters are 0, the drop counter is 0, the interrupt is low and each ring pointer sits at its ring base.
- R2: A pulse on the descriptor or status enqueue input adds the given count to that ring's credit counter only, visible after the next clock edge. The counter saturates at its all-ones value.
- R3: An accepted frame (valid with both credits non-zero) removes one credit from each ring and advances each ring pointer by one entry.
- R4: A ring pointer that steps onto base plus length returns to base, so every entry address stays inside its window.
- R5: Status word 0 has bit 31 set (processed), bit 30 set only when no error flag is set, bits 29 and 28 set (end of frame, end of buffer), and bits 20..16 equal to the error input. Error input bit 4 is overrun, 3 framing, 2 runt, 1 excess data and 0 CRC error. Bit 15 equals the CRC-included input.
- R6: Status word 1 has bit 31 set (processed), bits 30..16 equal to bits 30..16 of the descriptor word at the descriptor pointer, and bits 15..0 equal to the frame length.
- R7: The entry of a frame accepted at clock edge E is in the status ring at the status pointer from edge E+1 onward. The read port returns {word 1, word 0} on bits 63..0 one cycle after the address is presented.
- R8: A frame offered while either credit counter is zero writes no entry, changes no pointer or credit, and increments the drop counter (saturating).
- R9: The interrupt output is set in the cycle an entry is written, but only if the enable input is high in that cycle. It stays set until the clear input is pulsed, and a new entry takes priority over a clear in the same cycle.
- R10: A clear request zeroes both words of the addressed status entry. It is applied in the first cycle with no status write and is completed within two clock edges when no frame is being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dq_base | input | AW | Descriptor ring first entry index |
| dq_len | input | AW+1 | Descriptor ring size in entries |
| sq_base | input | AW | Status ring first entry index |
| sq_len | input | AW+1 | Status ring size in entries |
| desc_enq_valid | input | 1 | Return slots to the descriptor ring |
| desc_enq_cnt | input | CW | Number of descriptor slots returned |
| stat_enq_valid | input | 1 | Return slots to the status ring |
| stat_enq_cnt | input | CW | Number of status slots returned |
| desc_we | input | 1 | Descriptor word write strobe |
| desc_waddr | input | AW | Descriptor entry written |
| desc_wdata | input | 32 | Descriptor second word (index 30..16, buffer size 15..0) |
| fr_valid | input | 1 | A received frame has completed |
| fr_len | input | 16 | Frame length in bytes |
| fr_err | input | 5 | Error flags (overrun, framing, runt, excess, CRC) |
| fr_crc_incl | input | 1 | Length includes the CRC |
| irq_en | input | 1 | Receive interrupt enable |
| irq_clr | input | 1 | Clear the receive interrupt |
| sw_raddr | input | AW | Status entry read address |
| sw_rdata | output | 64 | Status entry read data, word 1 high |
| sw_clr | input | 1 | Zero a status entry |
| sw_caddr | input | AW | Status entry to zero |
| desc_credit | output | CW | Free descriptor slots |
| stat_credit | output | CW | Free status slots |
| drop_cnt | output | DROPW | Frames dropped for lack of credit |
| rx_irq | output | 1 | Sticky receive interrupt |

## Verification
A pointer that is off by one places an entry in the wrong slot. The scoreboard catches this on the first frame that reaches that slot, two edges after acceptance. A wrong wrap shows up only on the frame that crosses the ring end, which is why the stimulus crosses both ends at different frame counts. A credit that is counted wrongly shows on the credit outputs one edge later. It also shows as a dropped frame, or as an entry overwriting a slot the bench still models as stale data, and the bench checks that slot after the final drop.

// File: rtl/rx_stat_pkg.sv
package rx_stat_pkg;

  localparam int W0_DONE  = 31;
  localparam int W0_GOOD  = 30;
  localparam int W0_EOF   = 29;
  localparam int W0_EOB   = 28;
  localparam int W0_ERRLO = 16;
  localparam int W0_CRCIN = 15;
  localparam int W1_DONE  = 31;
  localparam int IDX_LO   = 16;
  localparam int IDX_W    = 15;

  typedef struct packed {
    logic ovr;
    logic frm;
    logic runt;
    logic xdata;
    logic crc;
  } rx_err_t;

  function automatic logic [31:0] pack_w0(input rx_err_t err, input logic crc_incl);
    logic [31:0] w;
    w = '0;
    w[W0_DONE]               = 1'b1;
    w[W0_GOOD]               = (err == '0);
    w[W0_EOF]                = 1'b1;
    w[W0_EOB]                = 1'b1;
    w[W0_ERRLO +: 5]         = err;
    w[W0_CRCIN]              = crc_incl;
    return w;
  endfunction

  function automatic logic [31:0] pack_w1(input logic [IDX_W-1:0] idx, input logic [15:0] len);
    logic [31:0] w;
    w                    = '0;
    w[W1_DONE]           = 1'b1;
    w[IDX_LO +: IDX_W]   = idx;
    w[15:0]              = len;
    return w;
  endfunction

endpackage

// File: rtl/rx_sdp_ram.sv
module rx_sdp_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/rx_ring_ctr.sv
module rx_ring_ctr #(
  parameter int AW = 6,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] base,
  input  logic [AW:0]   len,
  input  logic          enq_v,
  input  logic [CW-1:0] enq_n,
  input  logic          take,
  output logic [AW-1:0] ptr,
  output logic [CW-1:0] credit
);

  logic [AW:0]   inc;
  logic [AW:0]   stop;
  logic [AW-1:0] ptr_nxt;
  logic [CW:0]   sum;

  always_comb begin
    inc     = {1'b0, ptr} + 1'b1;
    stop    = {1'b0, base} + len;
    ptr_nxt = (inc == stop) ? base : inc[AW-1:0];
    sum     = {1'b0, credit} + (enq_v ? {1'b0, enq_n} : '0) - {{CW{1'b0}}, take};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr    <= base;
      credit <= '0;
    end else begin
      if (take) ptr <= ptr_nxt;
      credit <= sum[CW] ? '1 : sum[CW-1:0];
    end
  end

endmodule

// File: rtl/rx_stat_ring_wr.sv
module rx_stat_ring_wr
  import rx_stat_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DROPW = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    dq_base,
  input  logic [AW:0]      dq_len,
  input  logic [AW-1:0]    sq_base,
  input  logic [AW:0]      sq_len,
  input  logic             desc_enq_valid,
  input  logic [CW-1:0]    desc_enq_cnt,
  input  logic             stat_enq_valid,
  input  logic [CW-1:0]    stat_enq_cnt,
  input  logic             desc_we,
  input  logic [AW-1:0]    desc_waddr,
  input  logic [31:0]      desc_wdata,
  input  logic             fr_valid,
  input  logic [15:0]      fr_len,
  input  logic [4:0]       fr_err,
  input  logic             fr_crc_incl,
  input  logic             irq_en,
  input  logic             irq_clr,
  input  logic [AW-1:0]    sw_raddr,
  output logic [63:0]      sw_rdata,
  input  logic             sw_clr,
  input  logic [AW-1:0]    sw_caddr,
  output logic [CW-1:0]    desc_credit,
  output logic [CW-1:0]    stat_credit,
  output logic [DROPW-1:0] drop_cnt,
  output logic             rx_irq
);

  logic          accept;
  logic [AW-1:0] dq_ptr;
  logic [AW-1:0] sq_ptr;
  logic [31:0]   desc_word;

  // stage 1: frame accepted, descriptor word in flight from RAM
  logic          s1_v;
  logic [AW-1:0] s1_addr;
  logic [31:0]   s1_w0;
  logic [15:0]   s1_len;

  // one-deep pending clear
  logic          clr_p;
  logic [AW-1:0] clr_a;

  logic          st_we;
  logic [AW-1:0] st_waddr;
  logic [63:0]   st_wdata;

  assign accept = fr_valid && (desc_credit != '0) && (stat_credit != '0);

  rx_ring_ctr #(.AW(AW), .CW(CW)) u_dring (
    .clk(clk), .rst(rst), .base(dq_base), .len(dq_len),
    .enq_v(desc_enq_valid), .enq_n(desc_enq_cnt), .take(accept),
    .ptr(dq_ptr), .credit(desc_credit)
  );

  rx_ring_ctr #(.AW(AW), .CW(CW)) u_sring (
    .clk(clk), .rst(rst), .base(sq_base), .len(sq_len),
    .enq_v(stat_enq_valid), .enq_n(stat_enq_cnt), .take(accept),
    .ptr(sq_ptr), .credit(stat_credit)
  );

  rx_sdp_ram #(.W(32), .DEPTH(DEPTH)) u_dram (
    .clk(clk), .we(desc_we), .waddr(desc_waddr), .wdata(desc_wdata),
    .raddr(dq_ptr), .rdata(desc_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
    end else begin
      s1_v <= accept;
    end
    if (accept) begin
      s1_addr <= sq_ptr;
      s1_w0   <= pack_w0(rx_err_t'(fr_err), fr_crc_incl);
      s1_len  <= fr_len;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_p <= 1'b0;
      clr_a <= '0;
    end else if (sw_clr) begin
      clr_p <= 1'b1;
      clr_a <= sw_caddr;
    end else if (clr_p && !s1_v) begin
      clr_p <= 1'b0;
    end
  end

  always_comb begin
    st_we    = s1_v || clr_p;
    st_waddr = s1_v ? s1_addr : clr_a;
    st_wdata = s1_v ? {pack_w1(desc_word[IDX_LO +: IDX_W], s1_len), s1_w0} : 64'd0;
  end

  rx_sdp_ram #(.W(64), .DEPTH(DEPTH)) u_sram (
    .clk(clk), .we(st_we), .waddr(st_waddr), .wdata(st_wdata),
    .raddr(sw_raddr), .rdata(sw_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_irq   <= 1'b0;
      drop_cnt <= '0;
    end else begin
      if (s1_v && irq_en) rx_irq <= 1'b1;
      else if (irq_clr)   rx_irq <= 1'b0;
      if (fr_valid && !accept && (drop_cnt != '1)) drop_cnt <= drop_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/rx_stat_chk.sv
module rx_stat_chk #(
  parameter int AW    = 6,
  parameter int CW    = 7,
  parameter int DROPW = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [AW-1:0]    dq_base,
  input logic [AW:0]      dq_len,
  input logic [AW-1:0]    sq_base,
  input logic [AW:0]      sq_len,
  input logic [AW-1:0]    dq_ptr,
  input logic [AW-1:0]    sq_ptr,
  input logic             desc_enq_valid,
  input logic             stat_enq_valid,
  input logic             fr_valid,
  input logic             irq_en,
  input logic [CW-1:0]    desc_credit,
  input logic [CW-1:0]    stat_credit,
  input logic [DROPW-1:0] drop_cnt,
  input logic             rx_irq
);

  logic acc;
  assign acc = fr_valid && (desc_credit != '0) && (stat_credit != '0);

  assert_take_desc_R3: assert property (@(posedge clk) disable iff (rst)
    (acc && !desc_enq_valid) |=> desc_credit == $past(desc_credit) - 1'b1);

  assert_take_stat_R3: assert property (@(posedge clk) disable iff (rst)
    (acc && !stat_enq_valid) |=> stat_credit == $past(stat_credit) - 1'b1);

  assert_dptr_window_R4: assert property (@(posedge clk) disable iff (rst)
    (dq_len != '0) |-> (({1'b0, dq_ptr} >= {1'b0, dq_base}) &&
                        ({1'b0, dq_ptr} < ({1'b0, dq_base} + dq_len))));

  assert_sptr_window_R4: assert property (@(posedge clk) disable iff (rst)
    (sq_len != '0) |-> (({1'b0, sq_ptr} >= {1'b0, sq_base}) &&
                        ({1'b0, sq_ptr} < ({1'b0, sq_base} + sq_len))));

  assert_drop_count_R8: assert property (@(posedge clk) disable iff (rst)
    (fr_valid && !acc && drop_cnt != '1) |=> drop_cnt == $past(drop_cnt) + 1'b1);

  assert_drop_keeps_ptr_R8: assert property (@(posedge clk) disable iff (rst)
    (fr_valid && !acc) |=> ($stable(dq_ptr) && $stable(sq_ptr)));

  assert_irq_set_R9: assert property (@(posedge clk) disable iff (rst)
    (acc ##1 irq_en) |=> rx_irq);

  assert_irq_needs_en_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_irq) |-> $past(irq_en));

endmodule

bind rx_stat_ring_wr rx_stat_chk #(.AW(AW), .CW(CW), .DROPW(DROPW)) u_chk (
  .clk(clk), .rst(rst), .dq_base(dq_base), .dq_len(dq_len),
  .sq_base(sq_base), .sq_len(sq_len), .dq_ptr(dq_ptr), .sq_ptr(sq_ptr),
  .desc_enq_valid(desc_enq_valid), .stat_enq_valid(stat_enq_valid),
  .fr_valid(fr_valid), .irq_en(irq_en), .desc_credit(desc_credit),
  .stat_credit(stat_credit), .drop_cnt(drop_cnt), .rx_irq(rx_irq)
);

// File: tb/sim_rx_stat_ring_wr.sv
module sim_rx_stat_ring_wr;

  localparam int DEPTH = 64;
  localparam int DROPW = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = AW + 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst = 1'b1;
  logic [AW-1:0]    dq_base = 6'd4;
  logic [AW:0]      dq_len  = 7'd6;
  logic [AW-1:0]    sq_base = 6'd8;
  logic [AW:0]      sq_len  = 7'd5;
  logic             desc_enq_valid = 0, stat_enq_valid = 0;
  logic [CW-1:0]    desc_enq_cnt = 0, stat_enq_cnt = 0;
  logic             desc_we = 0;
  logic [AW-1:0]    desc_waddr = 0;
  logic [31:0]      desc_wdata = 0;
  logic             fr_valid = 0;
  logic [15:0]      fr_len = 0;
  logic [4:0]       fr_err = 0;
  logic             fr_crc_incl = 0;
  logic             irq_en = 0, irq_clr = 0;
  logic [AW-1:0]    sw_raddr = 0;
  logic [63:0]      sw_rdata;
  logic             sw_clr = 0;
  logic [AW-1:0]    sw_caddr = 0;
  logic [CW-1:0]    desc_credit, stat_credit;
  logic [DROPW-1:0] drop_cnt;
  logic             rx_irq;

  rx_stat_ring_wr #(.DEPTH(DEPTH), .DROPW(DROPW)) u0 (.*);

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [AW-1:0] addr;
    logic [63:0]   exp;
    bit            after_frame;
    string         tag;
  } sb_item_t;

  sb_item_t sb[$];

  // bench model
  logic [31:0] dmirror [DEPTH];
  logic [63:0] smirror [DEPTH];
  int dptr, sptr, dcr, scr, drops;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected entries and compares the read-port result
  initial begin
    sb_item_t it;
    forever begin
      wait (sb.size() != 0);
      it = sb[0];
      if (it.after_frame) begin
        @(posedge clk);
        @(posedge clk);
      end
      @(negedge clk);
      sw_raddr = it.addr;
      @(posedge clk);
      @(negedge clk);
      chk(sw_rdata === it.exp, it.tag, sw_rdata, it.exp);
      void'(sb.pop_front());
    end
  end

  function automatic logic [63:0] model_entry(input int idx_word, input logic [15:0] len,
                                              input logic [4:0] err, input logic crc);
    logic [31:0] w0, w1;
    w0 = 32'h8000_0000 | 32'h3000_0000 | ({27'd0, err} << 16) | ({31'd0, crc} << 15);
    if (err == 5'd0) w0 = w0 | 32'h4000_0000;
    w1 = 32'h8000_0000 | ({17'd0, dmirror[idx_word][30:16]} << 16) | {16'd0, len};
    return {w1, w0};
  endfunction

  task automatic send_frame(input logic [15:0] len, input logic [4:0] err, input logic crc, input string tag);
    sb_item_t it;
    @(negedge clk);
    it.addr = AW'(sptr);
    it.exp = model_entry(dptr, len, err, crc);
    it.after_frame = 1'b1;
    it.tag = tag;
    smirror[sptr] = it.exp;
    sb.push_back(it);
    fr_valid = 1; fr_len = len; fr_err = err; fr_crc_incl = crc;
    @(negedge clk);
    fr_valid = 0;
    dptr = (dptr + 1 == 4 + 6) ? 4 : dptr + 1;
    sptr = (sptr + 1 == 8 + 5) ? 8 : sptr + 1;
    dcr--; scr--;
    wait (sb.size() == 0);
    @(negedge clk);
  endtask

  task automatic send_drop(input string tag);
    @(negedge clk);
    fr_valid = 1; fr_len = 16'd64; fr_err = 0; fr_crc_incl = 0;
    @(negedge clk);
    fr_valid = 0;
    drops++;
    chk(drop_cnt == DROPW'(drops), {tag, " drop count"}, 64'(drop_cnt), 64'(drops));
    chk(desc_credit == CW'(dcr) && stat_credit == CW'(scr), {tag, " credits unchanged"},
        {32'(desc_credit), 32'(stat_credit)}, {32'(dcr), 32'(scr)});
  endtask

  task automatic enq(input bit d, input bit s, input int n);
    @(negedge clk);
    desc_enq_valid = d; stat_enq_valid = s;
    desc_enq_cnt = CW'(n); stat_enq_cnt = CW'(n);
    @(negedge clk);
    desc_enq_valid = 0; stat_enq_valid = 0;
    if (d) dcr += n;
    if (s) scr += n;
  endtask

  task automatic read_chk(input int addr, input logic [63:0] exp, input string tag);
    sb_item_t it;
    it.addr = AW'(addr); it.exp = exp; it.after_frame = 1'b0; it.tag = tag;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  bit done = 0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [4:0] errs [7];
    int lens [7];
    errs[0] = 5'b00000; errs[1] = 5'b10000; errs[2] = 5'b00001; errs[3] = 5'b00110;
    errs[4] = 5'b01000; errs[5] = 5'b00000; errs[6] = 5'b11111;
    lens[0] = 60; lens[1] = 1514; lens[2] = 2044; lens[3] = 20;
    lens[4] = 777; lens[5] = 1024; lens[6] = 64;
    dptr = 4; sptr = 8; dcr = 0; scr = 0; drops = 0;
    for (int i = 0; i < DEPTH; i++) smirror[i] = 64'd0;

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(desc_credit == 0, "R1 desc credit", 64'(desc_credit), 0);
    chk(stat_credit == 0, "R1 stat credit", 64'(stat_credit), 0);
    chk(drop_cnt == 0, "R1 drop count", 64'(drop_cnt), 0);
    chk(rx_irq == 0, "R1 irq", 64'(rx_irq), 0);

    send_drop("R8 no credit");

    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      desc_we = 1; desc_waddr = AW'(i);
      desc_wdata = {1'b0, 15'(200 + i * 3), 16'd2048};
      dmirror[i] = desc_wdata;
    end
    @(negedge clk);
    desc_we = 0;

    enq(1, 0, 3);
    chk(desc_credit == 3 && stat_credit == 0, "R2 desc enqueue only",
        {32'(desc_credit), 32'(stat_credit)}, {32'd3, 32'd0});
    send_drop("R8 status ring empty");

    enq(1, 1, 6);
    chk(desc_credit == 9 && stat_credit == 6, "R2 both enqueue",
        {32'(desc_credit), 32'(stat_credit)}, {32'd9, 32'd6});
    enq(0, 1, 3);
    chk(stat_credit == 9, "R2 status enqueue", 64'(stat_credit), 64'd9);

    irq_en = 1;
    for (int k = 0; k < 7; k++) begin
      send_frame(16'(lens[k]), errs[k], k[0],
                 (k >= 5) ? "R4 R5 R6 R7 wrapped entry" : "R5 R6 R7 entry");
      chk(desc_credit == CW'(dcr) && stat_credit == CW'(scr), "R3 credits after frame",
          {32'(desc_credit), 32'(stat_credit)}, {32'(dcr), 32'(scr)});
      chk(rx_irq == 1, "R9 irq after entry", 64'(rx_irq), 1);
    end

    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    chk(rx_irq == 0, "R9 irq cleared", 64'(rx_irq), 0);
    irq_en = 0;
    send_frame(16'd300, 5'b00000, 1'b0, "R7 entry irq disabled");
    chk(rx_irq == 0, "R9 irq stays low when disabled", 64'(rx_irq), 0);

    begin
      int last;
      last = (sptr == 8) ? 12 : sptr - 1;
      @(negedge clk); sw_clr = 1; sw_caddr = AW'(last);
      @(negedge clk); sw_clr = 0;
      @(negedge clk);
      smirror[last] = 64'd0;
      read_chk(last, 64'd0, "R10 cleared entry");
    end

    send_frame(16'd2044, 5'b00001, 1'b1, "R6 R7 maximum length");
    chk(desc_credit == 0 && stat_credit == 0, "R3 credits exhausted",
        {32'(desc_credit), 32'(stat_credit)}, 64'd0);
    send_drop("R8 after exhaustion");
    read_chk(sptr, smirror[sptr], "R8 next slot untouched");
    chk(u0.rx_irq == 0, "R9 no irq after drop", 64'(rx_irq), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule